// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block brings a DDR3 SDRAM from the moment its supplies are declared stable to the point where normal traffic may start. It watches a single power-good input, holds the memory in reset for a programmable time, releases reset while keeping the clock enable low, then raises the clock enable and waits out the exit-reset interval. After that it loads the four mode registers in a fixed order, issues a long ZQ calibration and waits for two independent timers: DLL lock and ZQ initialisation. When both have expired it raises a ready flag.

The four mode-register words come in as static configuration. The sequencer forces the DLL-enable bit of the extended register to the enabled value and sets the DLL-reset bit of the main register, so a careless configuration cannot leave the DLL off. Every delay is a parameter counted in controller clocks. All memory-side outputs and the ready flag leave the block through one register stage, so each pin changes one cycle after the internal decision that drives it. If the power-good input drops at any time, the block goes back to the reset-hold state and the whole sequence runs again from the start.

Top module: `ddr3_init_seq`

## Requirements
- R1: While `pwr_ok` is low, `mem_rst_n`, `mem_cke` and `init_done` are low, no later than the second clock edge after the low level is sampled, and they stay low for as long as `pwr_ok` stays low.
- R2: `mem_rst_n` rises T_RST + 1 clock edges after the first edge that samples `pwr_ok` high (T_RST cycles of hold plus one output register).
- R3: `mem_cke` is low whenever `mem_rst_n` is low, and it stays low for exactly T_CKE cycles after `mem_rst_n` rises.
- R4: Commands are encoded on {cs_n, ras_n, cas_n, we_n}: NOP = 0111, MRS = 0000, ZQCL = 0110. Until the first MRS, every cycle carries NOP. The first MRS comes exactly T_XPR cycles after `mem_cke` rises.
- R5: Exactly four MRS commands are issued, with bank address 3'b010, 3'b011, 3'b001 and 3'b000 in that order (registers 2, 3, 1, 0).
- R6: Each MRS drives the configured word for its register on `mem_addr`, except that bit 0 of register 1 is forced to 0 (DLL enabled) and bit 8 of register 0 is forced to 1 (DLL reset).
- R7: Consecutive MRS commands are exactly T_MRD cycles apart, and the cycle after an MRS carries a NOP.
- R8: ZQCL is issued exactly T_MOD cycles after the last MRS, with bank address 0 and `mem_addr` equal to only bit 10 set.
- R9: `init_done` rises one cycle after the later of (last MRS + T_DLLK) and (ZQCL + T_ZQINIT), and it then stays high while `pwr_ok` stays high.
- R10: Once `mem_cke` has risen, it stays high until `pwr_ok` drops. `mem_odt` is low throughout.
- R11: After `pwr_ok` drops in the middle of the sequence and rises again, the complete sequence repeats with the same timing as from a cold start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | Supplies stable; low forces the reset-hold state |
| mr0_cfg | input | ADDR_W | Word for mode register 0 |
| mr1_cfg | input | ADDR_W | Word for mode register 1 |
| mr2_cfg | input | ADDR_W | Word for mode register 2 |
| mr3_cfg | input | ADDR_W | Word for mode register 3 |
| mem_rst_n | output | 1 | Memory reset, active low |
| mem_cke | output | 1 | Memory clock enable |
| mem_odt | output | 1 | On-die termination control, held low |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | 3 | Bank address |
| mem_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Sequence complete, memory ready |

## Verification
The bench builds two instances with delays of a few cycles (reset hold 6, CKE wait 9, exit-reset 5, register spacing 4, last-register-to-ZQ 12). This lets a full sequence, a power drop halfway through the mode-register loads, a restart and a drop after ready all fit in a short run. One instance uses a DLL-lock wait of 40 and a ZQ wait of 20, so the DLL timer decides when ready rises. The other uses 16 and 30, so the ZQ timer decides. Between them, both branches of the completion rule are covered. The configuration words have the DLL-disable bit set and the DLL-reset bit cleared, so the bits the block forces can be seen on the address bus.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

    typedef enum logic [3:0] {
        ST_RST_HOLD,
        ST_CKE_WAIT,
        ST_XPR,
        ST_MRS,
        ST_MRD,
        ST_MOD,
        ST_ZQCL,
        ST_ZQWAIT,
        ST_READY
    } init_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } ddr_cmd_t;

    localparam ddr_cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam ddr_cmd_t CMD_MRS  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
    localparam ddr_cmd_t CMD_ZQCL = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};

    typedef struct packed {
        logic     rst_n;
        logic     cke;
        logic     odt;
        logic     done;
        ddr_cmd_t cmd;
    } ctl_pins_t;

    localparam ctl_pins_t CTL_IDLE = '{rst_n: 1'b0, cke: 1'b0, odt: 1'b0, done: 1'b0, cmd: CMD_NOP};

    localparam int MR_COUNT    = 4;
    localparam int BA_W        = 3;
    localparam int ZQ_LONG_BIT = 10;
    localparam int DLL_OFF_BIT = 0;
    localparam int DLL_RST_BIT = 8;

    typedef logic [1:0] mr_slot_t;

    // Load order: slot 0..3 maps to registers 2, 3, 1, 0
    function automatic logic [BA_W-1:0] slot_bank(mr_slot_t slot);
        logic [BA_W-1:0] ba;
        case (slot)
            2'd0:    ba = 3'b010;
            2'd1:    ba = 3'b011;
            2'd2:    ba = 3'b001;
            default: ba = 3'b000;
        endcase
        return ba;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr3_init_timer.sv
module ddr3_init_timer #(
    parameter int CYCLES = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic start,
    output logic expired
);
    localparam int W = $clog2(CYCLES + 1);

    logic [W-1:0] cnt;
    logic         armed;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (start) begin
            cnt   <= W'(CYCLES - 1);
            armed <= 1'b1;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Sticky once the count reaches zero after a start
    assign expired = armed && (cnt == '0);

endmodule

// File: rtl/ddr3_init_mrsel.sv
module ddr3_init_mrsel
    import ddr3_init_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic                       sel_mrs,
    input  logic                       sel_zq,
    input  mr_slot_t                   slot,
    input  logic [MR_COUNT*ADDR_W-1:0] cfg_flat,
    output logic [BA_W-1:0]            ba,
    output logic [ADDR_W-1:0]          addr
);
    logic [ADDR_W-1:0] mr_fixed [MR_COUNT];

    for (genvar g = 0; g < MR_COUNT; g++) begin : g_mr
        logic [ADDR_W-1:0] raw;
        assign raw = cfg_flat[g*ADDR_W +: ADDR_W];
        if (g == 0) begin : g_mr0
            always_comb begin
                mr_fixed[g] = raw;
                mr_fixed[g][DLL_RST_BIT] = 1'b1;
            end
        end else if (g == 1) begin : g_mr1
            always_comb begin
                mr_fixed[g] = raw;
                mr_fixed[g][DLL_OFF_BIT] = 1'b0;
            end
        end else begin : g_plain
            assign mr_fixed[g] = raw;
        end
    end

    logic [BA_W-1:0] slot_ba;
    assign slot_ba = slot_bank(slot);

    always_comb begin
        ba   = '0;
        addr = '0;
        if (sel_zq) begin
            addr[ZQ_LONG_BIT] = 1'b1;
        end else if (sel_mrs) begin
            ba   = slot_ba;
            addr = mr_fixed[slot_ba[1:0]];
        end
    end

endmodule

// File: rtl/ddr3_init_pins.sv
module ddr3_init_pins
    import ddr3_init_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_pins_t         ctl_d,
    input  logic [BA_W-1:0]   ba_d,
    input  logic [ADDR_W-1:0] addr_d,
    output ctl_pins_t         ctl_q,
    output logic [BA_W-1:0]   ba_q,
    output logic [ADDR_W-1:0] addr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= CTL_IDLE;
            ba_q   <= '0;
            addr_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            ba_q   <= ba_d;
            addr_q <= addr_d;
        end
    end

endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
    import ddr3_init_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int T_RST    = 80000,
    parameter int T_CKE    = 199999,
    parameter int T_XPR    = 144,
    parameter int T_MRD    = 4,
    parameter int T_MOD    = 12,
    parameter int T_DLLK   = 512,
    parameter int T_ZQINIT = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_ok,
    input  logic [ADDR_W-1:0] mr0_cfg,
    input  logic [ADDR_W-1:0] mr1_cfg,
    input  logic [ADDR_W-1:0] mr2_cfg,
    input  logic [ADDR_W-1:0] mr3_cfg,
    output logic              mem_rst_n,
    output logic              mem_cke,
    output logic              mem_odt,
    output logic              mem_cs_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [2:0]        mem_ba,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              init_done
);
    localparam int LONGEST = imax(imax(T_RST, T_CKE), imax(T_XPR, imax(T_MRD, T_MOD)));
    localparam int CNT_W   = $clog2(LONGEST + 1);
    localparam logic [CNT_W-1:0] LD_RST = CNT_W'(T_RST - 1);
    localparam logic [CNT_W-1:0] LD_CKE = CNT_W'(T_CKE - 1);
    localparam logic [CNT_W-1:0] LD_XPR = CNT_W'(T_XPR - 1);
    localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(T_MRD - 2);
    localparam logic [CNT_W-1:0] LD_MOD = CNT_W'(T_MOD - 2);

    init_state_e      st, st_nxt;
    logic [CNT_W-1:0] cnt, cnt_ld_val;
    logic             cnt_ld;
    mr_slot_t         slot;
    logic             dll_start, zq_start, dll_exp, zq_exp;

    // Sequencing decisions
    always_comb begin
        st_nxt     = st;
        cnt_ld     = 1'b0;
        cnt_ld_val = '0;
        dll_start  = 1'b0;
        zq_start   = 1'b0;
        case (st)
            ST_RST_HOLD: if (cnt == '0) begin
                st_nxt = ST_CKE_WAIT; cnt_ld = 1'b1; cnt_ld_val = LD_CKE;
            end
            ST_CKE_WAIT: if (cnt == '0) begin
                st_nxt = ST_XPR; cnt_ld = 1'b1; cnt_ld_val = LD_XPR;
            end
            ST_XPR: if (cnt == '0) st_nxt = ST_MRS;
            ST_MRS: begin
                cnt_ld = 1'b1;
                if (slot == mr_slot_t'(MR_COUNT - 1)) begin
                    dll_start = 1'b1;
                    st_nxt = ST_MOD; cnt_ld_val = LD_MOD;
                end else begin
                    st_nxt = ST_MRD; cnt_ld_val = LD_MRD;
                end
            end
            ST_MRD:    if (cnt == '0) st_nxt = ST_MRS;
            ST_MOD:    if (cnt == '0) st_nxt = ST_ZQCL;
            ST_ZQCL: begin
                zq_start = 1'b1;
                st_nxt   = ST_ZQWAIT;
            end
            ST_ZQWAIT: if (dll_exp && zq_exp) st_nxt = ST_READY;
            ST_READY:  st_nxt = ST_READY;
            default:   st_nxt = ST_RST_HOLD;
        endcase
        if (!pwr_ok) begin
            st_nxt     = ST_RST_HOLD;
            cnt_ld     = 1'b1;
            cnt_ld_val = LD_RST;
            dll_start  = 1'b0;
            zq_start   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_RST_HOLD;
            cnt  <= LD_RST;
            slot <= '0;
        end else begin
            st <= st_nxt;
            if (cnt_ld)
                cnt <= cnt_ld_val;
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
            if (!pwr_ok)
                slot <= '0;
            else if (st == ST_MRS && slot != mr_slot_t'(MR_COUNT - 1))
                slot <= slot + 1'b1;
        end
    end

    // DLL-lock and ZQ-init windows run side by side
    ddr3_init_timer #(.CYCLES(T_DLLK)) u_dll_tmr (
        .clk(clk), .rst(rst), .clr(!pwr_ok), .start(dll_start), .expired(dll_exp)
    );
    ddr3_init_timer #(.CYCLES(T_ZQINIT)) u_zq_tmr (
        .clk(clk), .rst(rst), .clr(!pwr_ok), .start(zq_start), .expired(zq_exp)
    );

    // Pin levels implied by the current state
    ctl_pins_t         ctl_d, ctl_q;
    logic [BA_W-1:0]   ba_d, ba_q;
    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        ctl_d       = CTL_IDLE;
        ctl_d.rst_n = (st != ST_RST_HOLD);
        ctl_d.cke   = !(st inside {ST_RST_HOLD, ST_CKE_WAIT});
        ctl_d.done  = (st == ST_READY);
        if (st == ST_MRS)
            ctl_d.cmd = CMD_MRS;
        else if (st == ST_ZQCL)
            ctl_d.cmd = CMD_ZQCL;
    end

    ddr3_init_mrsel #(.ADDR_W(ADDR_W)) u_mrsel (
        .sel_mrs (st == ST_MRS),
        .sel_zq  (st == ST_ZQCL),
        .slot    (slot),
        .cfg_flat({mr3_cfg, mr2_cfg, mr1_cfg, mr0_cfg}),
        .ba      (ba_d),
        .addr    (addr_d)
    );

    ddr3_init_pins #(.ADDR_W(ADDR_W)) u_pins (
        .clk(clk), .rst(rst),
        .ctl_d(ctl_d), .ba_d(ba_d), .addr_d(addr_d),
        .ctl_q(ctl_q), .ba_q(ba_q), .addr_q(addr_q)
    );

    assign mem_rst_n = ctl_q.rst_n;
    assign mem_cke   = ctl_q.cke;
    assign mem_odt   = ctl_q.odt;
    assign mem_cs_n  = ctl_q.cmd.cs_n;
    assign mem_ras_n = ctl_q.cmd.ras_n;
    assign mem_cas_n = ctl_q.cmd.cas_n;
    assign mem_we_n  = ctl_q.cmd.we_n;
    assign mem_ba    = ba_q;
    assign mem_addr  = addr_q;
    assign init_done = ctl_q.done;

endmodule

// File: rtl/ddr3_init_seq_chk.sv
module ddr3_init_seq_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              pwr_ok,
    input logic              mem_rst_n,
    input logic              mem_cke,
    input logic              mem_odt,
    input logic              mem_cs_n,
    input logic              mem_ras_n,
    input logic              mem_cas_n,
    input logic              mem_we_n,
    input logic [2:0]        mem_ba,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              init_done
);
    logic [3:0] cmd;
    assign cmd = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};

    a_r1_power_loss_resets: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok |-> ##2 (!mem_rst_n && !mem_cke && !init_done));

    a_r3_cke_low_in_reset: assert property (@(posedge clk) disable iff (rst)
        !mem_rst_n |-> !mem_cke);

    a_r4_nop_before_cke: assert property (@(posedge clk) disable iff (rst)
        !mem_cke |-> (cmd == 4'b0111));

    a_r7_nop_after_mrs: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0000) |=> (cmd == 4'b0111));

    a_r8_zqcl_long: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0110) |-> (mem_addr[10] && mem_ba == 3'b000));

    a_r9_done_powered: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (mem_cke && mem_rst_n && !mem_odt));

    a_r10_cke_holds: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_cke) |-> !$past(pwr_ok, 2));

endmodule

bind ddr3_init_seq ddr3_init_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok),
    .mem_rst_n(mem_rst_n), .mem_cke(mem_cke), .mem_odt(mem_odt),
    .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
    .mem_we_n(mem_we_n), .mem_ba(mem_ba), .mem_addr(mem_addr),
    .init_done(init_done)
);

// File: tb/ddr3_init_seq_test.sv
module ddr3_init_seq_test;
    localparam int AW = 15;
    localparam int TR = 6, TC = 9, TX = 5, TM = 4, TMOD = 12;
    localparam int DLLK_A = 40, ZQ_A = 20;
    localparam int DLLK_B = 16, ZQ_B = 30;
    localparam logic [AW-1:0] MR0 = 15'h0420, MR1 = 15'h0045, MR2 = 15'h0018, MR3 = 15'h0004;

    logic clk = 1'b0, rst = 1'b1, pwr_ok = 1'b0;
    always #2 clk = ~clk;

    logic rn, ck, od, cs, ra, ca, we, dn;
    logic [2:0] ba;
    logic [AW-1:0] ad;
    logic rn2, ck2, od2, cs2, ra2, ca2, we2, dn2;
    logic [2:0] ba2;
    logic [AW-1:0] ad2;

    ddr3_init_seq #(.ADDR_W(AW), .T_RST(TR), .T_CKE(TC), .T_XPR(TX), .T_MRD(TM),
                    .T_MOD(TMOD), .T_DLLK(DLLK_A), .T_ZQINIT(ZQ_A)) uut (
        .clk(clk), .rst(rst), .pwr_ok(pwr_ok),
        .mr0_cfg(MR0), .mr1_cfg(MR1), .mr2_cfg(MR2), .mr3_cfg(MR3),
        .mem_rst_n(rn), .mem_cke(ck), .mem_odt(od), .mem_cs_n(cs), .mem_ras_n(ra),
        .mem_cas_n(ca), .mem_we_n(we), .mem_ba(ba), .mem_addr(ad), .init_done(dn));

    ddr3_init_seq #(.ADDR_W(AW), .T_RST(TR), .T_CKE(TC), .T_XPR(TX), .T_MRD(TM),
                    .T_MOD(TMOD), .T_DLLK(DLLK_B), .T_ZQINIT(ZQ_B)) uut_zq (
        .clk(clk), .rst(rst), .pwr_ok(pwr_ok),
        .mr0_cfg(MR0), .mr1_cfg(MR1), .mr2_cfg(MR2), .mr3_cfg(MR3),
        .mem_rst_n(rn2), .mem_cke(ck2), .mem_odt(od2), .mem_cs_n(cs2), .mem_ras_n(ra2),
        .mem_cas_n(ca2), .mem_we_n(we2), .mem_ba(ba2), .mem_addr(ad2), .init_done(dn2));

    int checks = 0, failures = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Event log taken at negedges
    int rst_t, cke_t, zq_t, done_t, mrs_n, bad, cke_fall, odt_hi;
    int mrs_t [4];
    logic [2:0] mrs_ba [4];
    logic [AW-1:0] mrs_ad [4], zq_ad;
    logic [2:0] zq_ba;
    int mr0_t2, zq_t2, done_t2, mrs_n2;

    task automatic clear_log();
        rst_t = -1; cke_t = -1; zq_t = -1; done_t = -1; mrs_n = 0;
        bad = 0; cke_fall = 0; odt_hi = 0;
        mr0_t2 = -1; zq_t2 = -1; done_t2 = -1; mrs_n2 = 0;
        zq_ad = '0; zq_ba = '0;
        for (int i = 0; i < 4; i++) begin mrs_t[i] = -1; mrs_ba[i] = '0; mrs_ad[i] = '0; end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (rn && rst_t < 0) rst_t = cyc;
            if (ck && cke_t < 0) cke_t = cyc;
            if (!ck && cke_t >= 0 && pwr_ok) cke_fall++;
            if (od) odt_hi++;
            case ({cs, ra, ca, we})
                4'b0111: ;
                4'b0000: begin
                    if (mrs_n < 4) begin
                        mrs_t[mrs_n] = cyc; mrs_ba[mrs_n] = ba; mrs_ad[mrs_n] = ad;
                    end
                    if (cke_t < 0) bad++;
                    mrs_n++;
                end
                4'b0110: begin zq_t = cyc; zq_ad = ad; zq_ba = ba; end
                default: bad++;
            endcase
            if (dn && done_t < 0) done_t = cyc;
            if ({cs2, ra2, ca2, we2} == 4'b0000) begin
                mrs_n2++;
                if (mrs_n2 == 4) mr0_t2 = cyc;
            end
            if ({cs2, ra2, ca2, we2} == 4'b0110) zq_t2 = cyc;
            if (dn2 && done_t2 < 0) done_t2 = cyc;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset_state();
        rst = 1'b1; pwr_ok = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        // R1: held in reset while power is not good
        chk("R1", "rst_n idle", int'(rn), 0);
        chk("R1", "cke idle", int'(ck), 0);
        chk("R1", "done idle", int'(dn), 0);
        chk("R4", "idle cmd", int'({cs, ra, ca, we}), 7);
        chk("R10", "odt idle", int'(od), 0);
    endtask

    task automatic t_full_run(string tag);
        int p, lim, last;
        @(negedge clk);
        clear_log();
        p = cyc;
        pwr_ok = 1'b1;
        lim = 0;
        while ((done_t < 0 || done_t2 < 0) && lim < 3000) begin
            @(negedge clk); lim++;
        end
        $display("run %s", tag);
        chk("R2", "reset release", rst_t - p, TR + 1);
        chk("R3", "cke low after reset", cke_t - rst_t, TC);
        chk("R4", "first mrs after cke", mrs_t[0] - cke_t, TX);
        chk("R4", "illegal commands", bad, 0);
        chk("R5", "mrs count", mrs_n, 4);
        chk("R5", "ba slot0", int'(mrs_ba[0]), 2);
        chk("R5", "ba slot1", int'(mrs_ba[1]), 3);
        chk("R5", "ba slot2", int'(mrs_ba[2]), 1);
        chk("R5", "ba slot3", int'(mrs_ba[3]), 0);
        chk("R6", "mr2 word", int'(mrs_ad[0]), int'(MR2));
        chk("R6", "mr3 word", int'(mrs_ad[1]), int'(MR3));
        chk("R6", "mr1 dll enabled", int'(mrs_ad[2]), int'(MR1 & ~15'h0001));
        chk("R6", "mr0 dll reset", int'(mrs_ad[3]), int'(MR0 | 15'h0100));
        for (int i = 1; i < 4; i++) chk("R7", "mrs spacing", mrs_t[i] - mrs_t[i-1], TM);
        chk("R8", "zqcl after mr0", zq_t - mrs_t[3], TMOD);
        chk("R8", "zqcl addr", int'(zq_ad), 1024);
        chk("R8", "zqcl ba", int'(zq_ba), 0);
        last = (mrs_t[3] + DLLK_A > zq_t + ZQ_A) ? mrs_t[3] + DLLK_A : zq_t + ZQ_A;
        chk("R9", "done dll-bound", done_t, last + 1);
        last = (mr0_t2 + DLLK_B > zq_t2 + ZQ_B) ? mr0_t2 + DLLK_B : zq_t2 + ZQ_B;
        chk("R9", "done zq-bound", done_t2, last + 1);
        repeat (10) @(negedge clk);
        chk("R9", "done holds", int'(dn && dn2), 1);
        chk("R10", "cke never fell", cke_fall, 0);
        chk("R10", "odt stayed low", odt_hi, 0);
    endtask

    task automatic t_drop_after_done();
        @(negedge clk);
        pwr_ok = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R1", "done after drop", int'(dn), 0);
        chk("R1", "cke after drop", int'(ck), 0);
        chk("R1", "rst_n after drop", int'(rn), 0);
        repeat (30) @(negedge clk);
        chk("R1", "rst_n held low", int'(rn), 0);
    endtask

    task automatic t_drop_mid();
        int lim = 0;
        @(negedge clk);
        clear_log();
        pwr_ok = 1'b1;
        while (mrs_n < 2 && lim < 500) begin @(negedge clk); lim++; end
        chk("R11", "reached mrs phase", mrs_n, 2);
        pwr_ok = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R1", "mid drop rst_n", int'(rn), 0);
        chk("R1", "mid drop cke", int'(ck), 0);
        repeat (8) @(negedge clk);
        // R11: full sequence must repeat with cold-start timing
        t_full_run("R11 restart");
    endtask

    initial begin
        clear_log();
        t_reset_state();
        t_full_run("cold start");
        t_drop_after_done();
        t_drop_mid();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule